// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic heart of a simple accumulator-style processor datapath. It takes two 16-bit operands, the accumulator value and the value held in the memory buffer, and, under a 2-bit operation select, forms their sum, their bitwise AND, the two's-complement negation of the accumulator, or the accumulator shifted right by one bit with zero fill. The result appears combinationally on the output in the same cycle as the operands.

Alongside the result the block keeps a registered 4-bit status word holding negative, zero, carry and overflow flags. The word describes the most recent operation that was committed with the flag-enable strobe: it captures new values only on a rising clock edge while the strobe is high, and otherwise keeps its contents. The carry and overflow rules differ per operation. Negation reuses the adder with an inverted accumulator and a carry-in of one, so its carry and overflow fall out of the same carry chain as addition.

Top module: `accalu`

## Requirements
- R1: With select 2'b00, the result equals accumulator plus buffer, modulo 2^16.
- R2: With select 2'b01, the result equals the bitwise AND of accumulator and buffer.
- R3: With select 2'b10, the result equals the two's complement of the accumulator (~acc + 1, modulo 2^16); the buffer has no effect.
- R4: With select 2'b11, the result is the accumulator shifted right by one bit with bit 15 forced to zero; the buffer has no effect.
- R5: The status word is laid out as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V; on a committed operation N takes bit 15 of the result and Z is 1 exactly when the result is zero.
- R6: For addition, C is the carry out of bit 15 and V is 1 when both operands share a sign that the result does not.
- R7: For negation, C is 1 exactly when the accumulator is zero and V is 1 exactly when the accumulator is 16'h8000.
- R8: For the right shift, C receives accumulator bit 0 and V is 0.
- R9: For AND, C and V are both 0.
- R10: The status word changes only on a rising clock edge while the flag-enable strobe is high; with the strobe low it holds its value.
- R11: An active-low reset clears the status word to zero immediately, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the status word updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the status word |
| acc_i | input | 16 | Accumulator operand |
| mbr_i | input | 16 | Memory buffer operand |
| op_i | input | 2 | Operation select: 00 add, 01 AND, 10 negate, 11 shift right |
| flag_we_i | input | 1 | Flag-enable strobe; commits the current flags at the next edge |
| result_o | output | 16 | Combinational operation result |
| flags_o | output | 4 | Registered status word {N, Z, C, V} |

## Verification
The result is combinational, so it is due in the same cycle the operands and select are applied; the bench changes inputs on the falling clock edge and compares the result a short delay later, before any rising edge intervenes. The status word is due one rising edge after a stimulus with the strobe high, so the bench holds the inputs through that edge and compares the flags at the following falling edge against a bench-side shadow of the word, which it updates only when it drove the strobe high. Reset clearing is checked right after reset is asserted, without waiting for a clock edge.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_AND = 2'b01,
      OP_NEG = 2'b10,
      OP_SHR = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } status_t;

   localparam int STATUS_BITS = 4;

endpackage

// File: rtl/accalu_adder.sv
module accalu_adder #(
   parameter int WIDTH       = 16,
   parameter bit RIPPLE_IMPL = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);

   generate
      if (RIPPLE_IMPL) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o = cy[WIDTH];
         assign ovf_o  = cy[WIDTH] ^ cy[WIDTH-1];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
         assign sum_o  = wide[WIDTH-1:0];
         assign cout_o = wide[WIDTH];
         assign ovf_o  = (a_i[WIDTH-1] == b_i[WIDTH-1]) &&
                         (wide[WIDTH-1] != a_i[WIDTH-1]);
      end
   endgenerate

endmodule

// File: rtl/accalu_bitops.sv
module accalu_bitops #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] shr_o,
   output logic             shr_out_bit_o
);

   assign and_o         = a_i & b_i;
   assign shr_o         = {1'b0, a_i[WIDTH-1:1]};
   assign shr_out_bit_o = a_i[0];

endmodule

// File: rtl/accalu_flagreg.sv
module accalu_flagreg
   import accalu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    we_i,
   input  status_t next_i,
   output status_t flags_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_o <= '0;
      else if (we_i)
         flags_o <= next_i;
   end

   // R10: without the strobe the word must not move
   assert_flags_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(flags_o))
      else $error("status word changed without strobe");

   // R10: with the strobe the word takes the presented value
   assert_flags_load_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (flags_o == $past(next_i)))
      else $error("status word missed a strobed update");

endmodule

// File: rtl/accalu.sv
module accalu
   import accalu_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter bit RIPPLE_IMPL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] mbr_i,
   input  logic [1:0]       op_i,
   input  logic             flag_we_i,
   output logic [WIDTH-1:0] result_o,
   output logic [3:0]       flags_o
);

   localparam logic [WIDTH-1:0] ZERO_W  = '0;
   localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("accalu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   // shared carry chain: add uses (acc, mbr, 0), negate uses (~acc, 0, 1)
   logic [WIDTH-1:0] add_a, add_b, add_sum;
   logic             add_cin, add_cout, add_ovf;
   logic             is_neg;

   assign is_neg  = (op == OP_NEG);
   assign add_a   = is_neg ? ~acc_i : acc_i;
   assign add_b   = is_neg ? ZERO_W : mbr_i;
   assign add_cin = is_neg;

   accalu_adder #(
      .WIDTH       (WIDTH),
      .RIPPLE_IMPL (RIPPLE_IMPL)
   ) u_adder (
      .a_i    (add_a),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   logic [WIDTH-1:0] and_res, shr_res;
   logic             shr_bit;

   accalu_bitops #(
      .WIDTH (WIDTH)
   ) u_bitops (
      .a_i           (acc_i),
      .b_i           (mbr_i),
      .and_o         (and_res),
      .shr_o         (shr_res),
      .shr_out_bit_o (shr_bit)
   );

   status_t next_flags, cur_flags;
   logic [WIDTH-1:0] res;

   always_comb begin
      res          = add_sum;
      next_flags.c = add_cout;
      next_flags.v = add_ovf;
      unique case (op)
         OP_ADD, OP_NEG: begin
            res          = add_sum;
            next_flags.c = add_cout;
            next_flags.v = add_ovf;
         end
         OP_AND: begin
            res          = and_res;
            next_flags.c = 1'b0;
            next_flags.v = 1'b0;
         end
         OP_SHR: begin
            res          = shr_res;
            next_flags.c = shr_bit;
            next_flags.v = 1'b0;
         end
         default: ;
      endcase
      next_flags.n = res[WIDTH-1];
      next_flags.z = (res == ZERO_W);
   end

   assign result_o = res;

   accalu_flagreg u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (flag_we_i),
      .next_i  (next_flags),
      .flags_o (cur_flags)
   );

   assign flags_o = cur_flags;

   // R4: shifted result never carries a one in the top bit
   assert_shr_msb_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'b11) |-> (result_o[WIDTH-1] == 1'b0))
      else $error("shift left a one in the top bit");

   // R5: committed N follows the top bit of the result
   assert_neg_flag_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_i |=> (flags_o[3] == $past(result_o[WIDTH-1])))
      else $error("N flag does not follow result sign");

   // R7: negate carry and overflow depend only on the accumulator value
   assert_negate_flags_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i == 2'b10) |=>
         (flags_o[1] == ($past(acc_i) == ZERO_W)) &&
         (flags_o[0] == ($past(acc_i) == MIN_NEG)))
      else $error("negate C/V wrong");

   // R8: shift carry is the departing low bit
   assert_shift_carry_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i == 2'b11) |=>
         (flags_o[1] == $past(acc_i[0])) && !flags_o[0])
      else $error("shift C/V wrong");

   // R9: AND leaves carry and overflow clear
   assert_and_clears_cv_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && op_i == 2'b01) |=> (flags_o[1:0] == 2'b00))
      else $error("AND set C or V");

endmodule

// File: tb/accalu_test.sv
`timescale 1ns/100ps
module accalu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] acc = '0, mbr = '0;
   logic [1:0]  op = '0;
   logic        we = 1'b0;
   logic [15:0] result;
   logic [3:0]  flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [3:0] shadow = '0;

   always #2.5 clk = ~clk;

   accalu uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_i     (acc),
      .mbr_i     (mbr),
      .op_i      (op),
      .flag_we_i (we),
      .result_o  (result),
      .flags_o   (flags)
   );

   function automatic logic [15:0] exp_result(logic [15:0] a, logic [15:0] b, logic [1:0] o);
      case (o)
         2'b00:   return a + b;          // R1
         2'b01:   return a & b;          // R2
         2'b10:   return (~a) + 16'd1;   // R3
         default: return a >> 1;         // R4
      endcase
   endfunction

   function automatic logic [3:0] exp_flags(logic [15:0] a, logic [15:0] b, logic [1:0] o);
      logic [15:0] r;
      logic [16:0] w;
      logic c, v;
      r = exp_result(a, b, o);
      case (o)
         2'b00: begin                    // R6
            w = {1'b0, a} + {1'b0, b};
            c = w[16];
            v = (a[15] == b[15]) && (r[15] != a[15]);
         end
         2'b01: begin c = 1'b0; v = 1'b0; end             // R9
         2'b10: begin c = (a == 16'h0000); v = (a == 16'h8000); end  // R7
         default: begin c = a[0]; v = 1'b0; end           // R8
      endcase
      return {r[15], (r == 16'h0000), c, v};              // R5
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic string res_tag(logic [1:0] o);
      case (o)
         2'b00:   return "R1 add result";
         2'b01:   return "R2 and result";
         2'b10:   return "R3 negate result";
         default: return "R4 shift result";
      endcase
   endfunction

   function automatic string flag_tag(logic [1:0] o, logic w);
      if (!w) return "R10 flags hold";
      case (o)
         2'b00:   return "R6 add flags (R5 N/Z)";
         2'b01:   return "R9 and flags (R5 N/Z)";
         2'b10:   return "R7 negate flags (R5 N/Z)";
         default: return "R8 shift flags (R5 N/Z)";
      endcase
   endfunction

   // inputs change at a falling edge; result due at once, flags one rising edge later
   task automatic step(logic [15:0] a, logic [15:0] b, logic [1:0] o, logic w);
      @(negedge clk);
      acc = a; mbr = b; op = o; we = w;
      #1;
      check(res_tag(o), result, exp_result(a, b, o));
      if (w) shadow = exp_flags(a, b, o);
      @(negedge clk);
      check(flag_tag(o, w), {12'h0, flags}, {12'h0, shadow});
      we = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      #1;
      check("R11 reset state", {12'h0, flags}, 16'h0000);
      rst_n = 1'b1;

      // directed corners
      step(16'hFFFF, 16'h0001, 2'b00, 1'b1);  // R6 carry, zero result
      step(16'h7FFF, 16'h0001, 2'b00, 1'b1);  // R6 positive overflow
      step(16'h8000, 16'h8000, 2'b00, 1'b1);  // R6 negative overflow with carry
      step(16'h1234, 16'h0F0F, 2'b01, 1'b1);  // R2 / R9
      step(16'hF000, 16'h8000, 2'b01, 1'b1);  // R9 negative AND
      step(16'h0000, 16'hABCD, 2'b10, 1'b1);  // R7 zero input
      step(16'h8000, 16'h1111, 2'b10, 1'b1);  // R7 most negative
      step(16'h0001, 16'hFFFF, 2'b10, 1'b1);  // R3 with buffer ignored
      step(16'h8001, 16'hFFFF, 2'b11, 1'b1);  // R4 / R8 carry out
      step(16'h0001, 16'h0000, 2'b11, 1'b1);  // R8 shift to zero
      step(16'hFFFF, 16'h0001, 2'b00, 1'b0);  // R10 hold without strobe
      step(16'h0000, 16'h0000, 2'b11, 1'b0);  // R10 hold without strobe

      // mid-run reset: flags nonzero then cleared asynchronously
      step(16'h8000, 16'h0000, 2'b10, 1'b1);
      #0.7;
      rst_n = 1'b0;
      #0.3;
      shadow = '0;
      check("R11 async reset clears", {12'h0, flags}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [15:0] a, b;
         logic [1:0]  o;
         logic        w;
         a = 16'($urandom);
         b = 16'($urandom);
         o = 2'($urandom);
         w = ($urandom % 4) != 0;
         case ($urandom % 8)
            0: a = 16'h0000;
            1: a = 16'h8000;
            2: b = ~a;
            default: ;
         endcase
         step(a, b, o, w);
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule